// File: doc/BRIEF.md
# Two-Stage Timebase Watchdog

This block is a memory-mapped watchdog timer driven by a free-running timebase. Software arms it by setting two enable bits that live in two different registers. While both are set, an interval counter runs over 2^N clock cycles. The first time that interval elapses, a state flag is raised and the interrupt output goes high. Software then services the watchdog by writing ones to both status bits, which clears the flag and restarts the interval. If the interval elapses a second time with the flag still set, the block issues a fixed-width system reset request and latches a sticky reset-status flag that survives until software clears it. The time from the last service to a reset is therefore two full intervals.

A build-time option locks the watchdog on. Once both enables have been seen set together, it can no longer be turned off except by the hardware reset of the block itself. A read-only register exposes the free-running timebase, which lets software confirm that the clock is alive. Access is through a simple single-cycle 32-bit register port. Read data is registered one cycle after the address.

Top module: `wdog_top`

## Requirements
- R1: Registers are word-aligned on `bus_addr[3:2]`: index 0 (byte offset 0x0) is control 0, index 1 (0x4) is control 1, index 2 (0x8) is the timebase, and index 3 (0xC) reads zero. `bus_rdata` shows the register addressed in the previous cycle. Control 0 holds the reset status in bit 3, the watchdog state in bit 2 and the first enable in bit 1. Control 1 holds the second enable in bit 0.
- R2: The interval counter advances only while both enable bits are 1. Clearing either enable stops the watchdog, and no expiry, interrupt or reset request follows.
- R3: When the watchdog goes from stopped to running, the interval counter starts from zero. The next expiry occurs exactly 2^N cycles after the clock edge that completed the enable. An expiry with the state bit clear sets the state bit.
- R4: Writing 1 to bit 3 or bit 2 of control 0 clears that bit, and writing 0 leaves it unchanged. Writing 1 to both bits in one write is a service: it also restarts the interval, so the next expiry comes 2^N cycles after the service edge.
- R5: An expiry while the state bit is set raises `sys_rst_req` for exactly PULSE_W cycles, starting on the cycle after that expiry. It also sets the reset-status bit, which is mirrored on `rst_flag` and stays set until cleared by a write of 1.
- R6: `irq` is a level equal to the state bit ANDed with both enable bits. It drops when either enable clears and returns when the watchdog is re-enabled with the state bit still set.
- R7: The timebase register counts up by one every clock, so reads on consecutive cycles differ by exactly one. Writes to it have no effect.
- R8: With ENABLE_ONCE set, once both enables have been 1 together, writes that would clear either enable are ignored until the block is reset. Before that point, the enables clear normally.
- R9: Reserved bits read as zero, and writes to them have no effect.
- R10: After reset, all registers and the `irq`, `sys_rst_req` and `rst_flag` outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | 4 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq | output | 1 | Interrupt level after the first expiry |
| sys_rst_req | output | 1 | Reset request pulse after the second expiry |
| rst_flag | output | 1 | Sticky copy of the reset-status bit |

## Verification
The bench times the first expiry to the exact cycle after an enable and after a service. A counter that is not cleared on enable, or not restarted by a service, would expire early and trip the cycle-accurate interrupt checks. It measures the reset pulse width and confirms that the status bit persists after the pulse. A design that reset the status early, or stretched the pulse by a cycle, would miscompare. Two instances, with and without the lock option, receive the same writes: one must stop and mask the interrupt, and the other must ignore the clears. A write that clears only the reset-status bit must not count as a service. Re-enabling with the state bit still set must restore the interrupt and fire a reset one interval later.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  localparam int DATA_W = 32;
  localparam int ADDR_W = 4;

  // bit positions decoded by software
  localparam int BIT_RSTS = 3;
  localparam int BIT_WDS  = 2;
  localparam int BIT_EN1  = 1;
  localparam int BIT_EN2  = 0;

  typedef enum logic [1:0] {
    SEL_CTL0 = 2'd0,
    SEL_CTL1 = 2'd1,
    SEL_TB   = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  function automatic reg_sel_e decode_addr(input logic [ADDR_W-1:0] a);
    reg_sel_e s;
    case (a[3:2])
      2'd0:    s = SEL_CTL0;
      2'd1:    s = SEL_CTL1;
      2'd2:    s = SEL_TB;
      default: s = SEL_NONE;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/wdog_timebase.sv
module wdog_timebase #(
  parameter int TB_W = 32
) (
  input  logic            clk,
  input  logic            rst,
  output logic [TB_W-1:0] count
);

  always_ff @(posedge clk) begin
    if (rst) count <= '0;
    else     count <= count + 1'b1;
  end

  AST_TB_STEP: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (count == $past(count) + 1'b1)) else $error("timebase step"); // R7

endmodule

// File: rtl/wdog_interval.sv
module wdog_interval #(
  parameter int INTERVAL_W = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic restart,
  output logic expire
);

  logic [INTERVAL_W-1:0] cnt_q;

  // counter is held at zero while stopped, so enabling starts a full interval
  always_ff @(posedge clk) begin
    if (rst || !run || restart) cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end

  assign expire = run && !restart && (&cnt_q);

  AST_EXPIRE_WRAPS: assert property (@(posedge clk) disable iff (rst)
    expire |=> (cnt_q == '0)) else $error("interval wrap"); // R3

endmodule

// File: rtl/wdog_pulse.sv
module wdog_pulse #(
  parameter int PULSE_W = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic fire,
  output logic req
);

  localparam int PC_W = $clog2(PULSE_W + 1);

  logic [PC_W-1:0] left_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      left_q <= '0;
      req    <= 1'b0;
    end else if (fire) begin
      left_q <= PC_W'(PULSE_W);
      req    <= 1'b1;
    end else begin
      if (left_q != '0) left_q <= left_q - 1'b1;
      req <= (left_q > PC_W'(1));
    end
  end

  AST_PULSE_START: assert property (@(posedge clk) disable iff (rst)
    fire |=> req) else $error("pulse start"); // R5

endmodule

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int TB_W        = 32,
  parameter bit ENABLE_ONCE = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [TB_W-1:0]   tb_count,
  input  logic              expire,
  output logic              run,
  output logic              restart,
  output logic              fire,
  output logic              rsts,
  output logic              irq,
  output logic [DATA_W-1:0] rdata
);

  reg_sel_e sel;
  logic     wr0, wr1;
  logic     en1_q, en2_q, wds_q, rsts_q, irq_q;
  logic     en1_n, en2_n, wds_n, rsts_n;
  logic     lock;
  logic [DATA_W-1:0] tb_ext;
  logic     unused_bits;

  assign sel = decode_addr(addr);
  assign wr0 = wr && (sel == SEL_CTL0);
  assign wr1 = wr && (sel == SEL_CTL1);

  assign restart = wr0 && wdata[BIT_RSTS] && wdata[BIT_WDS];
  assign fire    = expire && wds_q;
  assign run     = en1_q && en2_q;

  always_comb begin
    en1_n = en1_q;
    en2_n = en2_q;
    if (wr0) en1_n = lock ? 1'b1 : wdata[BIT_EN1];
    if (wr1) en2_n = lock ? 1'b1 : wdata[BIT_EN2];

    // an expiry sets the state bit and wins over a same-cycle clear
    if (expire)                     wds_n = 1'b1;
    else if (wr0 && wdata[BIT_WDS]) wds_n = 1'b0;
    else                            wds_n = wds_q;

    if (fire)                        rsts_n = 1'b1;
    else if (wr0 && wdata[BIT_RSTS]) rsts_n = 1'b0;
    else                             rsts_n = rsts_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en1_q  <= 1'b0;
      en2_q  <= 1'b0;
      wds_q  <= 1'b0;
      rsts_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      en1_q  <= en1_n;
      en2_q  <= en2_n;
      wds_q  <= wds_n;
      rsts_q <= rsts_n;
      irq_q  <= wds_n && en1_n && en2_n;
    end
  end

  generate
    if (ENABLE_ONCE) begin : g_lock
      logic lock_q;
      always_ff @(posedge clk) begin
        if (rst)                 lock_q <= 1'b0;
        else if (en1_n && en2_n) lock_q <= 1'b1;
      end
      assign lock = lock_q;

      AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (rst)
        lock_q |=> (en1_q && en2_q)) else $error("lock released"); // R8
    end else begin : g_nolock
      assign lock = 1'b0;
    end
  endgenerate

  always_comb begin
    tb_ext = '0;
    tb_ext[TB_W-1:0] = tb_count;
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else begin
      rdata <= '0;
      case (sel)
        SEL_CTL0: begin
          rdata[BIT_RSTS] <= rsts_q;
          rdata[BIT_WDS]  <= wds_q;
          rdata[BIT_EN1]  <= en1_q;
        end
        SEL_CTL1: rdata[BIT_EN2] <= en2_q;
        SEL_TB:   rdata <= tb_ext;
        default:  rdata <= '0;
      endcase
    end
  end

  assign rsts = rsts_q;
  assign irq  = irq_q;
  assign unused_bits = ^{wdata[DATA_W-1:4], addr[1:0]};

  AST_IRQ_LEVEL: assert property (@(posedge clk) disable iff (rst)
    irq_q == (wds_q && en1_q && en2_q)) else $error("irq level"); // R6
  AST_FIRE_FLAGS: assert property (@(posedge clk) disable iff (rst)
    fire |=> rsts_q) else $error("reset status"); // R5
  AST_FIRST_EXPIRY: assert property (@(posedge clk) disable iff (rst)
    (expire && !wds_q) |=> wds_q) else $error("first expiry"); // R3
  AST_STOPPED_QUIET: assert property (@(posedge clk) disable iff (rst)
    !run |-> !expire) else $error("expiry while stopped"); // R2

endmodule

// File: rtl/wdog_top.sv
module wdog_top
  import wdog_pkg::*;
#(
  parameter int INTERVAL_W  = 16,
  parameter int PULSE_W     = 16,
  parameter int TB_W        = 32,
  parameter bit ENABLE_ONCE = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq,
  output logic              sys_rst_req,
  output logic              rst_flag
);

  logic [TB_W-1:0] tb_count;
  logic run, restart, expire, fire;

  wdog_timebase #(.TB_W(TB_W)) u_tb (
    .clk(clk), .rst(rst), .count(tb_count)
  );

  wdog_interval #(.INTERVAL_W(INTERVAL_W)) u_ivl (
    .clk(clk), .rst(rst), .run(run), .restart(restart), .expire(expire)
  );

  wdog_regs #(.TB_W(TB_W), .ENABLE_ONCE(ENABLE_ONCE)) u_regs (
    .clk(clk), .rst(rst), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .tb_count(tb_count), .expire(expire), .run(run), .restart(restart),
    .fire(fire), .rsts(rst_flag), .irq(irq), .rdata(bus_rdata)
  );

  wdog_pulse #(.PULSE_W(PULSE_W)) u_pulse (
    .clk(clk), .rst(rst), .fire(fire), .req(sys_rst_req)
  );

  AST_REQ_FLAGGED: assert property (@(posedge clk) disable iff (rst)
    $rose(sys_rst_req) |-> rst_flag) else $error("req without flag"); // R5

endmodule

// File: tb/tb_wdog_top.sv
module tb_wdog_top;

  localparam int N   = 6;
  localparam int PW  = 5;
  localparam int IVL = 1 << N;

  typedef struct packed {
    logic [3:0]  waddr;
    logic [31:0] wdata;
    logic [3:0]  raddr;
    logic [31:0] exp;
  } vec_t;

  // watchdog stays stopped throughout (second enable never set with the first)
  localparam vec_t VEC [8] = '{
    '{4'h0, 32'h0000_0002, 4'h0, 32'h0000_0002},  // R1 first enable bit 1
    '{4'h0, 32'hFFFF_FFFF, 4'h0, 32'h0000_0002},  // R9 R4 reserved ignored, w1c on zero
    '{4'h4, 32'hFFFF_FFFE, 4'h4, 32'h0000_0000},  // R9 reserved in control 1
    '{4'h8, 32'h0000_FFFF, 4'h0, 32'h0000_0002},  // R7 timebase write ignored
    '{4'hC, 32'hFFFF_FFFF, 4'hC, 32'h0000_0000},  // R1 unused slot reads zero
    '{4'h0, 32'h0000_0000, 4'h0, 32'h0000_0000},  // R8 clear before lock engages
    '{4'h4, 32'h0000_0001, 4'h4, 32'h0000_0001},  // R1 second enable bit 0
    '{4'h4, 32'h0000_0000, 4'h4, 32'h0000_0000}   // R2 clear second enable
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] rd_a, rd_b;
  logic        irq_a, irq_b, req_a, req_b, flag_a, flag_b;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  wdog_top #(.INTERVAL_W(N), .PULSE_W(PW), .ENABLE_ONCE(1'b0)) dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(rd_a), .irq(irq_a),
    .sys_rst_req(req_a), .rst_flag(flag_a)
  );

  wdog_top #(.INTERVAL_W(N), .PULSE_W(PW), .ENABLE_ONCE(1'b1)) dut_lk (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(rd_b), .irq(irq_b),
    .sys_rst_req(req_b), .rst_flag(flag_b)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr_t(input logic [3:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_t(input logic [3:0] a);
    bus_addr = a;
    @(negedge clk);
  endtask

  task automatic wait_irq(input string req);
    int early = 0;
    for (int k = 1; k < IVL; k++) begin
      @(negedge clk);
      if (irq_a) early++;
    end
    check(req, early, 0);
    @(negedge clk);
    check(req, irq_a, 1'b1);
  endtask

  task automatic wait_req(input string req);
    int early = 0;
    for (int k = 1; k < IVL; k++) begin
      @(negedge clk);
      if (req_a) early++;
    end
    check(req, early, 0);
    @(negedge clk);
    check(req, req_a, 1'b1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R10 reset state
    rd_t(4'h0); check("R10", rd_a, 0);
    rd_t(4'h4); check("R10", rd_a, 0);
    check("R10", {irq_a, req_a, flag_a}, 0);

    for (int i = 0; i < 8; i++) begin
      wr_t(VEC[i].waddr, VEC[i].wdata);
      rd_t(VEC[i].raddr);
      check("R1 R9 vec", rd_a, VEC[i].exp);
      check("R8 vec lk", rd_b, VEC[i].exp);
    end

    // R7 consecutive timebase reads
    begin
      logic [31:0] v1;
      rd_t(4'h8); v1 = rd_a;
      @(negedge clk);
      check("R7", rd_a, v1 + 1);
    end

    // R3 first expiry a full interval after enable
    wr_t(4'h0, 32'h2);
    wr_t(4'h4, 32'h1);
    wait_irq("R3");
    rd_t(4'h0); check("R3", rd_a, 32'h6);

    // R4 service clears and restarts interval
    wr_t(4'h0, 32'hE);
    check("R4", irq_a, 1'b0);
    wait_irq("R4");

    // R5 second unserviced expiry
    wait_req("R5");
    check("R5", flag_a, 1'b1);
    for (int k = 1; k < PW; k++) begin
      @(negedge clk);
      check("R5 width", req_a, 1'b1);
    end
    @(negedge clk);
    check("R5 width end", req_a, 1'b0);
    rd_t(4'h0); check("R5 sticky", rd_a, 32'hE);

    // R4 clearing only reset status is not a service
    wr_t(4'h0, 32'hA);
    check("R4", flag_a, 1'b0);
    rd_t(4'h0); check("R4", rd_a, 32'h6);

    // R2 R6 R8 disable: unlocked stops, locked ignores
    wr_t(4'h4, 32'h0);
    check("R6", irq_a, 1'b0);
    check("R8", irq_b, 1'b1);
    wr_t(4'h0, 32'h0);
    rd_t(4'h4); check("R2", rd_a, 0); check("R8", rd_b, 1);
    rd_t(4'h0); check("R2", rd_a, 32'h4); check("R8", rd_b, 32'h6);
    begin
      int seen = 0;
      for (int k = 0; k < 3 * IVL; k++) begin
        @(negedge clk);
        if (req_a || irq_a) seen++;
      end
      check("R2 stopped", seen, 0);
    end
    rd_t(4'h0); check("R2", rd_a, 32'h4);

    // R6 re-enable with state still set, then R3 reset one interval later
    wr_t(4'h0, 32'h2);
    wr_t(4'h4, 32'h1);
    check("R6", irq_a, 1'b1);
    wait_req("R3 reenable");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule